// File: doc/BRIEF.md
# Memory-Op Accumulator-Read Stall Checker

This block sits next to the issue stage of a vector core that has a matrix unit. Every cycle it is told what issued in the previous slot, or that the slot was a bubble. It keeps a short record of those slots: the class of each one (plain vector ALU op, accumulator-read, matrix op, or anything else) and the vector-register range each one wrote. A load or store that wants to issue is offered as a candidate with up to three vector source ranges. From the record, the block works out how many wait states the candidate still needs before it may go, and whether it may go now.

Two dependencies lead to a stall. In the direct case, the memory op reads a register that a recent accumulator-read wrote. In the indirect case, an accumulator-read issued in the slot just before, and the memory op reads a register that a plain vector ALU op wrote one or two slots before that accumulator-read. The stall is the largest need over all the source ranges of the candidate. When the matrix feature is off, or the candidate is not a memory op, the stall is zero.

Ages below count slots. Age 0 is the slot that ended at the latest clock edge. A bubble fills a slot in the same way as an issue does.

Top module: `hz_memop_accrd_chk`

## Requirements
- R1: If the age-0 slot is an accumulator-read (class code 2) whose destination range overlaps a source range of a valid memory candidate, the stall is 2.
- R2: If the age-1 slot is an accumulator-read whose destination overlaps a source range, that source range needs a stall of 1.
- R3: If the age-0 slot is an accumulator-read, and a plain vector ALU write (class code 1) at age 1 or age 2 overlaps a source range, that range needs 1. This holds even when the accumulator-read's own destination is unrelated. Matrix-op writes (class code 3) and other writes (class code 0) never cause this.
- R4: A source range gets a stall of 0 in these cases: it overlaps no accumulator-read at age 0 or 1, and it matches no indirect pattern. An accumulator-read at age 2 or older has no effect. A vector ALU write with no accumulator-read at age 0 has no effect.
- R5: When feature_en is low, the stall is 0 whatever the history holds.
- R6: When cand_is_mem is low or cand_vld is low, the stall is 0.
- R7: A source slot with count 0 is not a vector operand and never causes a stall, whatever its base value.
- R8: The stall is the maximum of the needs of the three source slots.
- R9: A range is base..base+count-1. Any shared register counts as overlap, and ranges that only touch at their ends do not overlap.
- R10: A slot with iss_vld low is recorded as a bubble. It ages older entries by one slot and adds no dependency.
- R11: Reset clears the history, so right after reset every candidate sees a stall of 0.
- R12: ready is high exactly when cand_vld is high and the stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one issue slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| feature_en | input | 1 | Matrix feature present; low turns the checker off |
| iss_vld | input | 1 | An instruction issues in this slot; low marks a bubble |
| iss_cls | input | 2 | Class of the issuing op: 0 other, 1 vector ALU, 2 accumulator-read, 3 matrix op |
| iss_base | input | REG_W (8) | First vector register written by the issuing op |
| iss_cnt | input | CNT_W (3) | Number of registers written (0 for none) |
| cand_vld | input | 1 | A candidate instruction is offered |
| cand_is_mem | input | 1 | The candidate is a load or store |
| cand_src_base | input | N_SRC*REG_W (24) | First register of each source slot, slot 0 in the low bits |
| cand_src_cnt | input | N_SRC*CNT_W (9) | Register count of each source slot, 0 for no vector operand |
| stall | output | 2 | Wait states the candidate still needs (0 to 2) |
| ready | output | 1 | Candidate may issue this cycle |

## Verification
stall and ready depend only on the current candidate inputs and on the recorded history, so they are due in the same cycle the candidate is driven. A slot driven on iss_* counts as age 0 from the cycle after its clock edge, and it moves one age older at each edge after that. The bench drives every input just after the falling edge and compares a little later in the same low phase. It adds the slot to its own history list only after the rising edge that captures it, which keeps its ages the same as the design's. Directed sequences use a flush of three bubbles between cases so that each case starts from a known history.

// File: rtl/hzm_pkg.sv
package hzm_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_VALU   = 2'd1,
    CLS_ACCRD  = 2'd2,
    CLS_MATRIX = 2'd3
  } slot_cls_e;

  // wait states owed to a direct accumulator-read result consumer
  localparam int DIRECT_WAIT   = 2;
  // wait states owed when an accumulator-read separates an ALU write from its consumer
  localparam int INDIRECT_WAIT = 1;
  // how many slots before the accumulator-read an ALU write still matters
  localparam int INDIRECT_SPAN = 2;
  // history depth needed to cover both rules
  localparam int HIST_DEPTH    = (INDIRECT_SPAN + 1 > DIRECT_WAIT) ? INDIRECT_SPAN + 1 : DIRECT_WAIT;
  localparam int STALL_W       = $clog2(DIRECT_WAIT + 1);

  // two register ranges [base, base+cnt) share at least one register
  function automatic logic ranges_meet(input logic [31:0] a_base, input logic [31:0] a_cnt,
                                       input logic [31:0] b_base, input logic [31:0] b_cnt);
    if (a_cnt == 32'd0 || b_cnt == 32'd0) return 1'b0;
    return (a_base < b_base + b_cnt) && (b_base < a_base + a_cnt);
  endfunction

  // need left by an accumulator-read sitting at a given age
  function automatic int direct_need(input int age);
    return (age < DIRECT_WAIT) ? DIRECT_WAIT - age : 0;
  endfunction

endpackage

// File: rtl/hz_history.sv
module hz_history
  import hzm_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 3,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  slot_cls_e        iss_cls,
  input  logic [REG_W-1:0] iss_base,
  input  logic [CNT_W-1:0] iss_cnt,
  output slot_cls_e        h_cls  [DEPTH],
  output logic [REG_W-1:0] h_base [DEPTH],
  output logic [CNT_W-1:0] h_cnt  [DEPTH]
);

  // what enters the youngest entry: a bubble records nothing
  slot_cls_e        in_cls;
  logic [REG_W-1:0] in_base;
  logic [CNT_W-1:0] in_cnt;

  always_comb begin
    in_cls  = iss_vld ? iss_cls  : CLS_OTHER;
    in_base = iss_vld ? iss_base : '0;
    in_cnt  = iss_vld ? iss_cnt  : '0;
  end

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          h_cls[k]  <= CLS_OTHER;
          h_base[k] <= '0;
          h_cnt[k]  <= '0;
        end else if (k == 0) begin
          h_cls[k]  <= in_cls;
          h_base[k] <= in_base;
          h_cnt[k]  <= in_cnt;
        end else begin
          h_cls[k]  <= h_cls[k-1];
          h_base[k] <= h_base[k-1];
          h_cnt[k]  <= h_cnt[k-1];
        end
      end

      if (k > 0) begin : g_chk
        p_age_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
          rst_n |=> (h_cls[k] == $past(h_cls[k-1]) && h_cnt[k] == $past(h_cnt[k-1])));
      end
    end
  endgenerate

  p_bubble_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_vld |=> (h_cnt[0] == '0 && h_cls[0] == CLS_OTHER));

endmodule

// File: rtl/hz_opnd_match.sv
module hz_opnd_match
  import hzm_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 3,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   src_base,
  input  logic [CNT_W-1:0]   src_cnt,
  input  slot_cls_e          h_cls  [DEPTH],
  input  logic [REG_W-1:0]   h_base [DEPTH],
  input  logic [CNT_W-1:0]   h_cnt  [DEPTH],
  output logic [STALL_W-1:0] op_need,
  output logic               indirect_hit
);

  logic [DEPTH-1:0] age_hit;
  logic [STALL_W-1:0] dir_need;
  logic alu_behind;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_hit
      assign age_hit[k] = ranges_meet(32'(h_base[k]), 32'(h_cnt[k]), 32'(src_base), 32'(src_cnt));
    end
  endgenerate

  always_comb begin
    dir_need = '0;
    for (int k = 0; k < DIRECT_WAIT; k++) begin
      if (h_cls[k] == CLS_ACCRD && age_hit[k] && STALL_W'(direct_need(k)) > dir_need)
        dir_need = STALL_W'(direct_need(k));
    end
  end

  always_comb begin
    alu_behind = 1'b0;
    for (int k = 1; k <= INDIRECT_SPAN; k++) begin
      if (h_cls[k] == CLS_VALU && age_hit[k]) alu_behind = 1'b1;
    end
  end

  assign indirect_hit = (h_cls[0] == CLS_ACCRD) && alu_behind;

  always_comb begin
    op_need = dir_need;
    if (indirect_hit && op_need < STALL_W'(INDIRECT_WAIT)) op_need = STALL_W'(INDIRECT_WAIT);
  end

  p_no_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_cnt == '0) |-> (op_need == '0));

  p_fresh_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cls[0] == CLS_ACCRD && age_hit[0]) |-> (op_need == STALL_W'(DIRECT_WAIT)));

  p_indirect_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    indirect_hit |-> (op_need >= STALL_W'(INDIRECT_WAIT)));

endmodule

// File: rtl/hz_memop_accrd_chk.sv
module hz_memop_accrd_chk
  import hzm_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 3,
  parameter int N_SRC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   feature_en,
  input  logic                   iss_vld,
  input  logic [1:0]             iss_cls,
  input  logic [REG_W-1:0]       iss_base,
  input  logic [CNT_W-1:0]       iss_cnt,
  input  logic                   cand_vld,
  input  logic                   cand_is_mem,
  input  logic [N_SRC*REG_W-1:0] cand_src_base,
  input  logic [N_SRC*CNT_W-1:0] cand_src_cnt,
  output logic [1:0]             stall,
  output logic                   ready
);

  localparam int DEPTH = HIST_DEPTH;

  slot_cls_e        h_cls  [DEPTH];
  logic [REG_W-1:0] h_base [DEPTH];
  logic [CNT_W-1:0] h_cnt  [DEPTH];

  logic [STALL_W-1:0] op_need [N_SRC];
  logic [N_SRC-1:0]   op_indirect;
  logic [STALL_W-1:0] worst_need;
  logic               check_on;
  logic               iss_hits_op0;

  hz_history #(.REG_W(REG_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_vld  (iss_vld),
    .iss_cls  (slot_cls_e'(iss_cls)),
    .iss_base (iss_base),
    .iss_cnt  (iss_cnt),
    .h_cls    (h_cls),
    .h_base   (h_base),
    .h_cnt    (h_cnt)
  );

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_op
      hz_opnd_match #(.REG_W(REG_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_base     (cand_src_base[i*REG_W +: REG_W]),
        .src_cnt      (cand_src_cnt[i*CNT_W +: CNT_W]),
        .h_cls        (h_cls),
        .h_base       (h_base),
        .h_cnt        (h_cnt),
        .op_need      (op_need[i]),
        .indirect_hit (op_indirect[i])
      );
    end
  endgenerate

  always_comb begin
    worst_need = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (op_need[i] > worst_need) worst_need = op_need[i];
    end
  end

  assign check_on = feature_en && cand_vld && cand_is_mem;
  assign stall    = check_on ? 2'(worst_need) : 2'd0;
  assign ready    = cand_vld && (stall == 2'd0);

  assign iss_hits_op0 = ranges_meet(32'(iss_base), 32'(iss_cnt),
                                    32'(cand_src_base[REG_W-1:0]), 32'(cand_src_cnt[CNT_W-1:0]));

  p_stall_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall <= 2'(DIRECT_WAIT));

  p_feature_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !feature_en |-> (stall == 2'd0));

  p_non_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand_is_mem || !cand_vld) |-> (stall == 2'd0));

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cand_vld && stall == 2'd0));

  p_indirect_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (check_on && |op_indirect) |-> (stall != 2'd0));

  p_direct_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_cls == 2'(CLS_ACCRD) && check_on && iss_hits_op0)
    |=> (!$stable(cand_src_base) || !$stable(cand_src_cnt) || !check_on || stall == 2'(DIRECT_WAIT)));

endmodule

// File: tb/hz_memop_accrd_chk_bench.sv
`timescale 1ns/1ps
module hz_memop_accrd_chk_bench;

  localparam int REG_W = 8;
  localparam int CNT_W = 3;
  localparam int N_SRC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feature_en = 1'b1;
  logic iss_vld = 1'b0;
  logic [1:0] iss_cls = 2'd0;
  logic [REG_W-1:0] iss_base = '0;
  logic [CNT_W-1:0] iss_cnt = '0;
  logic cand_vld = 1'b0;
  logic cand_is_mem = 1'b0;
  logic [N_SRC*REG_W-1:0] cand_src_base = '0;
  logic [N_SRC*CNT_W-1:0] cand_src_cnt = '0;
  logic [1:0] stall;
  logic ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural history, index 0 is the youngest slot
  int q_cls[$];
  int q_base[$];
  int q_cnt[$];

  always #4 clk = ~clk;

  hz_memop_accrd_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .N_SRC(N_SRC)) u_hz_memop_accrd_chk (
    .clk(clk), .rst_n(rst_n), .feature_en(feature_en),
    .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_base(iss_base), .iss_cnt(iss_cnt),
    .cand_vld(cand_vld), .cand_is_mem(cand_is_mem),
    .cand_src_base(cand_src_base), .cand_src_cnt(cand_src_cnt),
    .stall(stall), .ready(ready)
  );

  function automatic bit meet(int ab, int ac, int bb, int bc);
    if (ac == 0 || bc == 0) return 0;
    for (int r = ab; r < ab + ac; r++)
      if (r >= bb && r < bb + bc) return 1;
    return 0;
  endfunction

  function automatic int model_stall();
    int worst = 0;
    if (!feature_en || !cand_vld || !cand_is_mem) return 0;
    for (int i = 0; i < N_SRC; i++) begin
      int b = int'(cand_src_base[i*REG_W +: REG_W]);
      int c = int'(cand_src_cnt[i*CNT_W +: CNT_W]);
      int need = 0;
      if (q_cls[0] == 2 && meet(q_base[0], q_cnt[0], b, c)) need = 2;
      else if (q_cls[1] == 2 && meet(q_base[1], q_cnt[1], b, c)) need = 1;
      if (q_cls[0] == 2 && need < 1 &&
          ((q_cls[1] == 1 && meet(q_base[1], q_cnt[1], b, c)) ||
           (q_cls[2] == 1 && meet(q_base[2], q_cnt[2], b, c)))) need = 1;
      if (need > worst) worst = need;
    end
    return worst;
  endfunction

  task automatic clear_model();
    q_cls.delete(); q_base.delete(); q_cnt.delete();
    for (int k = 0; k < 3; k++) begin
      q_cls.push_back(0); q_base.push_back(0); q_cnt.push_back(0);
    end
  endtask

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // one slot: issue record, candidate, literal expectation (-1 = model only)
  task automatic step(bit iv, int cl, int ib, int ic, bit cv, bit mem,
                      int b0, int c0, int b1, int c1, int b2, int c2,
                      bit fe, int exp, string tag);
    int m;
    @(negedge clk);
    iss_vld = iv; iss_cls = 2'(cl); iss_base = REG_W'(ib); iss_cnt = CNT_W'(ic);
    cand_vld = cv; cand_is_mem = mem; feature_en = fe;
    cand_src_base = {REG_W'(b2), REG_W'(b1), REG_W'(b0)};
    cand_src_cnt  = {CNT_W'(c2), CNT_W'(c1), CNT_W'(c0)};
    #1;
    m = model_stall();
    check({tag, " stall/model"}, int'(stall), m);
    check("R12 ready/model", int'(ready), int'(cand_vld && m == 0));
    if (exp >= 0) check({tag, " stall/expected"}, int'(stall), exp);
    @(posedge clk);
    #1;
    if (rst_n) begin
      q_cls.push_front(iv ? cl : 0);
      q_base.push_front(iv ? ib : 0);
      q_cnt.push_front(iv ? ic : 0);
      void'(q_cls.pop_back()); void'(q_base.pop_back()); void'(q_cnt.pop_back());
    end else clear_model();
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, -1, "R10 flush");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; iss_vld = 0; cand_vld = 0;
    repeat (2) @(posedge clk);
    #1;
    clear_model();
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();
    // R11: empty history after reset
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 0, "R11");
    check("R12 ready after reset", int'(ready), 1);

    // R1 / R2 / R4: accumulator-read to v4 ages out
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R1 setup");
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 2, "R1");
    check("R12 ready low while stalled", int'(ready), 0);
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 1, "R2");
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 0, "R4 aged out");
    flush();

    // R9: partial overlap and touching ranges
    step(1,2,8,1, 0,0, 0,0,0,0,0,0, 1, -1, "R9 setup");
    step(0,0,0,0, 1,1, 6,4, 0,0, 0,0, 1, 2, "R9 partial");
    flush();
    step(1,2,8,2, 0,0, 0,0,0,0,0,0, 1, -1, "R9 setup");
    step(0,0,0,0, 1,1, 10,2, 6,2, 0,0, 1, 0, "R9 touching");
    flush();

    // R3: indirect at age 1 and age 2; matrix does not count
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(1,2,2,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(0,0,0,0, 1,1, 0,2, 0,0, 0,0, 1, 1, "R3 age1");
    flush();
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(1,0,5,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(1,2,2,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(0,0,0,0, 1,1, 0,1, 0,0, 0,0, 1, 1, "R3 age2");
    flush();
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R4 setup");
    step(1,0,5,1, 0,0, 0,0,0,0,0,0, 1, -1, "R4 setup");
    step(1,0,6,1, 0,0, 0,0,0,0,0,0, 1, -1, "R4 setup");
    step(1,2,2,1, 0,0, 0,0,0,0,0,0, 1, -1, "R4 setup");
    step(0,0,0,0, 1,1, 0,1, 0,0, 0,0, 1, 0, "R4 ALU too old");
    flush();
    step(1,3,0,4, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(1,2,8,1, 0,0, 0,0,0,0,0,0, 1, -1, "R3 setup");
    step(0,0,0,0, 1,1, 0,1, 0,0, 0,0, 1, 0, "R3 matrix ignored");
    flush();
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R4 setup");
    step(0,0,0,0, 1,1, 0,1, 0,0, 0,0, 1, 0, "R4 ALU alone");
    flush();

    // R5 / R6 / R7
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R5 setup");
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 0, 0, "R5");
    flush();
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R6 setup");
    step(0,0,0,0, 1,0, 4,1, 0,0, 0,0, 1, 0, "R6 not memory");
    check("R6 ready for non-memory", int'(ready), 1);
    flush();
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R6 setup");
    step(0,0,0,0, 0,1, 4,1, 0,0, 0,0, 1, 0, "R6 no candidate");
    check("R12 ready without candidate", int'(ready), 0);
    flush();
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R7 setup");
    step(0,0,0,0, 1,1, 4,0, 20,1, 4,0, 1, 0, "R7");
    flush();

    // R8: maximum over slots
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R8 setup");
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R8 setup");
    step(0,0,0,0, 1,1, 0,1, 30,1, 4,1, 1, 2, "R8 direct wins");
    flush();
    step(1,1,0,1, 0,0, 0,0,0,0,0,0, 1, -1, "R8 setup");
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R8 setup");
    step(0,0,0,0, 1,1, 30,1, 0,1, 31,1, 1, 1, "R8 middle slot");
    flush();

    // R10: bubbles age the history
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R10 setup");
    step(0,0,0,0, 0,0, 0,0,0,0,0,0, 1, -1, "R10 bubble");
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 1, "R10 one bubble");
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 0, "R10 two bubbles");

    // R11: reset in mid-flight
    step(1,2,4,1, 0,0, 0,0,0,0,0,0, 1, -1, "R11 setup");
    do_reset();
    step(0,0,0,0, 1,1, 4,1, 0,0, 0,0, 1, 0, "R11 mid reset");

    // mixed traffic, compared against the model every cycle (R8)
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0,1), $urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3),
           $urandom_range(0,7) != 0, $urandom_range(0,5) != 0,
           $urandom_range(0,7), $urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3),
           $urandom_range(0,7), $urandom_range(0,3), $urandom_range(0,9) != 0, -1, "R8 mixed");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule